// File: doc/BRIEF.md
# Flash Program/Erase Status Read Generator

This block models the device side of the status read path of a parallel NOR flash. A command strobe starts an embedded program or erase. While that operation runs, a read returns a status byte in place of array data. Bit 7 carries the polarity flag: it is the inverse of the pending data bit 7 for a program, and 0 for an erase. Bit 6 flips on every status read. A completion pulse from an external behavioural timer ends a normal operation.

A request that targets a protected sector does not wait for the completion pulse. It stays busy for a fixed window counted in clock cycles and then goes back to read mode with the array left unchanged. The window is about 1 µs for a program and about 150 µs for an erase. Both windows are derived from a clock-frequency parameter. The array is reduced to one latched byte and its address; every other location reads as erased (FFh).

At completion, the first read may already show the final value on bit 7 while bits 6..0 still show the previous status. Fully valid data appears on the read after that.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, rd_data is 00h and a read at any address returns FFh.
- R2: A read issued while a program is busy returns bit 7 equal to the inverse of bit 7 of the byte being programmed, with bits 5..0 at 0.
- R3: Bit 6 of the status byte inverts on each successive status read while an operation is busy.
- R4: While an erase is busy, bit 7 of the status byte is 0. After completion, the latched byte is FFh, so bit 7 reads 1.
- R5: After op_done ends an operation, the first read returns {final bit 7, bit 6 of the last status read, 000000b}. The next read returns the full array byte.
- R6: A read in the same cycle as the accepted command strobe still returns array data. Status appears from the following cycle on.
- R7: A program request to a protected sector stays busy for exactly PROG_ABORT_US × (CLK_HZ/1e6) cycles and ignores op_done. Bit 7 reads the inverse of the pending data bit 7 throughout. The latched byte is then unchanged.
- R8: An erase request to a protected sector stays busy for exactly ERASE_ABORT_US × (CLK_HZ/1e6) cycles, with bit 6 toggling on each read. The latched byte is then unchanged.
- R9: A command strobe that arrives while an operation is busy has no effect.
- R10: An op_done pulse while idle changes nothing.
- R11: A completed program replaces the single latched byte. Other addresses read FFh, and rd_data holds its value when rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command accepted strobe (one cycle) |
| cmd_erase | input | 1 | 1 = erase, 0 = program |
| cmd_addr | input | AW | Target address |
| cmd_data | input | 8 | Byte to program |
| cmd_prot | input | 1 | Target sector is protected |
| op_done | input | 1 | Completion pulse from the behavioural timer |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Read data, registered, valid the cycle after rd_en |

## Verification
The assertions assume that cmd_valid and op_done are single-cycle pulses driven away from the clock edge. They also assume that op_done is only meaningful while an unprotected operation runs. The stimulus drives every strobe for exactly one cycle from the falling edge. It deliberately sends op_done while idle and during a protected abort, and sends a second command while busy, so that the "ignored" properties see their triggering condition. Status reads are issued back to back, so the toggle property sees consecutive status reads.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_RUN, OP_ABORT} op_state_e;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/flash_op_tracker.sv
module flash_op_tracker
  import flash_status_pkg::*;
#(
  parameter int AW        = 8,
  parameter int PROG_CYC  = 50,
  parameter int ERASE_CYC = 7500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_erase,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_data,
  input  logic          cmd_prot,
  input  logic          op_done,
  output logic          busy,
  output logic          op_erase,
  output logic          op_bit7,
  output logic          done_evt,
  output logic [AW-1:0] arr_addr,
  output logic [7:0]    arr_data
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  op_state_e     st_q, st_d;
  logic          erase_q, erase_d;
  logic [AW-1:0] addr_q, addr_d, arr_addr_q, arr_addr_d;
  logic [7:0]    data_q, data_d, arr_data_q, arr_data_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          accept, finish_run, finish_abort;

  assign accept       = (st_q == OP_IDLE) && cmd_valid;
  assign finish_run   = (st_q == OP_RUN) && op_done;
  assign finish_abort = (st_q == OP_ABORT) && (cnt_q == '0);

  always_comb begin
    st_d       = st_q;
    erase_d    = erase_q;
    addr_d     = addr_q;
    data_d     = data_q;
    cnt_d      = cnt_q;
    arr_addr_d = arr_addr_q;
    arr_data_d = arr_data_q;
    done_evt   = 1'b0;
    case (st_q)
      OP_IDLE: if (accept) begin
        erase_d = cmd_erase;
        addr_d  = cmd_addr;
        data_d  = cmd_data;
        if (cmd_prot) begin
          st_d  = OP_ABORT;
          cnt_d = cmd_erase ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
        end else begin
          st_d = OP_RUN;
        end
      end
      OP_RUN: if (finish_run) begin
        st_d     = OP_IDLE;
        done_evt = 1'b1;
        if (erase_q) begin
          arr_data_d = ERASED_BYTE;
        end else begin
          arr_addr_d = addr_q;
          arr_data_d = data_q;
        end
      end
      OP_ABORT: begin
        if (finish_abort) begin
          st_d     = OP_IDLE;
          done_evt = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: st_d = OP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= OP_IDLE;
      erase_q    <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
      cnt_q      <= '0;
      arr_addr_q <= '0;
      arr_data_q <= ERASED_BYTE;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (accept) begin
        erase_q <= erase_d;
        addr_q  <= addr_d;
        data_q  <= data_d;
      end
      if (finish_run) begin
        arr_addr_q <= arr_addr_d;
        arr_data_q <= arr_data_d;
      end
    end
  end

  assign busy     = (st_q != OP_IDLE);
  assign op_erase = erase_q;
  assign op_bit7  = data_q[7];
  assign arr_addr = arr_addr_q;
  assign arr_data = arr_data_q;

  a_r9_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != OP_IDLE && cmd_valid) |=>
      (addr_q == $past(addr_q) && data_q == $past(data_q) && erase_q == $past(erase_q)));

  a_r7_abort_keeps_array: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == OP_ABORT) |=> (arr_data_q == $past(arr_data_q) && arr_addr_q == $past(arr_addr_q)));

  a_r10_idle_done_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == OP_IDLE && op_done) |=> $stable(arr_data_q));
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
  import flash_status_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          op_erase,
  input  logic          op_bit7,
  input  logic          done_evt,
  input  logic [AW-1:0] arr_addr,
  input  logic [7:0]    arr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] rd_q, rd_d, arr_byte;
  logic       tog_q, tog_d, settle_q, settle_d, poll_bit;

  assign arr_byte = (rd_addr == arr_addr) ? arr_data : ERASED_BYTE;
  assign poll_bit = op_erase ? 1'b0 : ~op_bit7;

  always_comb begin
    rd_d     = rd_q;
    tog_d    = tog_q;
    settle_d = settle_q;
    if (rd_en) begin
      if (busy) begin
        tog_d    = ~tog_q;
        rd_d     = {poll_bit, ~tog_q, 6'b0};
        settle_d = 1'b0;
      end else if (settle_q) begin
        rd_d     = {arr_byte[7], tog_q, 6'b0};
        settle_d = 1'b0;
      end else begin
        rd_d = arr_byte;
      end
    end
    if (done_evt) settle_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= '0;
      tog_q    <= 1'b0;
      settle_q <= 1'b0;
    end else begin
      settle_q <= settle_d;
      if (rd_en) begin
        rd_q  <= rd_d;
        tog_q <= tog_d;
      end
    end
  end

  assign rd_data = rd_q;

  a_r4_erase_bit7_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_erase && rd_en) |=> !rd_data[7]);

  a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en && $past(busy && rd_en)) |=> (rd_data[6] != $past(rd_data[6])));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int AW             = 8,
  parameter int CLK_HZ         = 50_000_000,
  parameter int PROG_ABORT_US  = 1,
  parameter int ERASE_ABORT_US = 150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_erase,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_data,
  input  logic          cmd_prot,
  input  logic          op_done,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int CYC_PER_US = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
  localparam int PROG_CYC   = (PROG_ABORT_US * CYC_PER_US > 1) ? PROG_ABORT_US * CYC_PER_US : 2;
  localparam int ERASE_CYC  = (ERASE_ABORT_US * CYC_PER_US > 1) ? ERASE_ABORT_US * CYC_PER_US : 2;

  logic          sync1_q, rst_sync_n;
  logic          busy, op_erase, op_bit7, done_evt;
  logic [AW-1:0] arr_addr;
  logic [7:0]    arr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      sync1_q    <= 1'b1;
      rst_sync_n <= sync1_q;
    end
  end

  flash_op_tracker #(.AW(AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_trk (
    .clk(clk), .rst_n(rst_sync_n),
    .cmd_valid(cmd_valid), .cmd_erase(cmd_erase), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_prot(cmd_prot), .op_done(op_done),
    .busy(busy), .op_erase(op_erase), .op_bit7(op_bit7), .done_evt(done_evt),
    .arr_addr(arr_addr), .arr_data(arr_data)
  );

  flash_read_mux #(.AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_sync_n),
    .busy(busy), .op_erase(op_erase), .op_bit7(op_bit7), .done_evt(done_evt),
    .arr_addr(arr_addr), .arr_data(arr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;
  localparam int AW = 8;
  localparam int PN = 50;
  localparam int EN = 7500;
  localparam logic [15:0] VEC [0:3] = '{16'h105A, 16'h20C3, 16'h1080, 16'hFE00};

  logic clk = 1'b0;
  logic rst_n, cmd_valid, cmd_erase, cmd_prot, op_done, rd_en;
  logic [AW-1:0] cmd_addr, rd_addr;
  logic [7:0] cmd_data, rd_data, s1, s2, r;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_status_gen dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_erase(cmd_erase),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_prot(cmd_prot),
    .op_done(op_done), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic er, input logic [7:0] a, input logic [7:0] d, input logic p);
    cmd_valid = 1; cmd_erase = er; cmd_addr = a; cmd_data = d; cmd_prot = p;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic pulse_done();
    op_done = 1;
    @(negedge clk);
    op_done = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    v = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_erase = 0; cmd_prot = 0; op_done = 0;
    rd_en = 0; cmd_addr = 0; cmd_data = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset rd_data", rd_data, 8'h00);
    rd(8'h00, r); chk("R1 erased read", r, 8'hFF);

    // table-driven program sequences
    for (int i = 0; i < 4; i++) begin
      logic [7:0] a, d;
      a = VEC[i][15:8]; d = VEC[i][7:0];
      cmd(1'b0, a, d, 1'b0);
      rd(a, s1);
      chk("R2 poll bit7", {7'b0, s1[7]}, {7'b0, ~d[7]});
      chk("R2 low bits zero", {2'b0, s1[5:0]}, 8'h00);
      rd(a, s2);
      chk("R3 toggle", {7'b0, s2[6]}, {7'b0, ~s1[6]});
      pulse_done();
      rd(a, r); chk("R5 first read after done", r, {d[7], s2[6], 6'b0});
      rd(a, r); chk("R5 full data", r, d);
      rd(a ^ 8'h01, r); chk("R11 other address erased", r, 8'hFF);
    end

    // R6: read coincident with command strobe sees array data
    rd_en = 1; rd_addr = 8'hFE;
    cmd(1'b1, 8'hFE, 8'h00, 1'b0);
    rd_en = 0;
    chk("R6 read with strobe", rd_data, 8'h00);
    rd(8'hFE, r); chk("R4 erase bit7 low", {7'b0, r[7]}, 8'h00);
    pulse_done();
    rd(8'hFE, r); chk("R4 erase done bit7", {7'b0, r[7]}, 8'h01);
    rd(8'hFE, r); chk("R4 erased byte", r, 8'hFF);
    chk("R3 no toggle idle", rd_data, 8'hFF);

    // R9: command while busy is ignored
    cmd(1'b0, 8'h30, 8'h12, 1'b0);
    cmd(1'b0, 8'h40, 8'h80, 1'b1);
    rd(8'h30, r); chk("R9 status unchanged", {7'b0, r[7]}, 8'h01);
    pulse_done();
    rd(8'h30, r);
    rd(8'h30, r); chk("R9 first op stored", r, 8'h12);
    rd(8'h40, r); chk("R9 second op dropped", r, 8'hFF);

    // R10: op_done while idle
    pulse_done();
    rd(8'h30, r); chk("R10 idle done ignored", r, 8'h12);

    // R11: hold when no read
    repeat (5) @(negedge clk);
    chk("R11 hold", rd_data, 8'h12);

    // R7: protected program
    cmd(1'b0, 8'h30, 8'h00, 1'b1);
    pulse_done();
    repeat (PN - 3) @(negedge clk);
    rd(8'h30, s1); chk("R7 status late", s1 & 8'hBF, 8'h80);
    rd(8'h30, s2); chk("R7 status last cycle", s2 & 8'hBF, 8'h80);
    rd(8'h30, r);  chk("R7 back to read", r, {1'b0, s2[6], 6'b0});
    rd(8'h30, r);  chk("R7 array unchanged", r, 8'h12);

    // R8: protected erase
    cmd(1'b1, 8'h30, 8'h00, 1'b1);
    pulse_done();
    repeat (EN - 3) @(negedge clk);
    rd(8'h30, s1); chk("R8 status bit7", s1 & 8'hBF, 8'h00);
    rd(8'h30, s2); chk("R8 toggle", {7'b0, s2[6]}, {7'b0, ~s1[6]});
    rd(8'h30, r);  chk("R8 back to read", r, {1'b0, s2[6], 6'b0});
    rd(8'h30, r);  chk("R8 array unchanged", r, 8'h12);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule